// File: doc/BRIEF.md
# Fuse Array Auto-Read Controller

This block sits between a register bus and a one-time-programmable fuse array and turns a short sequence of register writes into a timed read of one array word. Software first programs a word address into the control register and confirms it with an address-set strobe. It then raises a read-start strobe, polls a busy flag until it drops, and collects the word from a read-only data register. The word address is the byte offset divided by the word size. The word size is fixed at build time to one byte or four bytes, over an array of 512 bytes.

The control register also holds a power-down bit and a read-enable bit, and a second configuration register holds an encryption-enable bit. A start strobe launches a read only when read-enable is set and power-down is clear. A group of write-path fields is held as plain storage and read back exactly as written; nothing acts on it. The array itself stays outside the block. The controller drives a read request, a word address and a power-down line toward the array, and after a fixed number of cycles it captures what the array returns.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, which is power-down set and every other bit 0. The data register (offset 0x08) and the configuration register (offset 0x10) read 0, and `fuse_pd` is 1.
- R2: A control write that sets bit 11 while the stored bit 11 is 0, with no read running, copies that write's bits 10:0 to `fuse_addr`. Changing bits 10:0 without that strobe leaves `fuse_addr` unchanged.
- R3: A control write that sets bit 25 while the stored bit 25 is 0, carrying bit 24 = 1 and bit 27 = 0 with no read running, makes busy (bit 26 of the control register) read 1 on the very next bus read.
- R4: Once launched, busy reads 1 for exactly RD_LATENCY consecutive cycles. After it clears, the data register holds the array word at the latched address, with byte 0 in bits 7:0.
- R5: A start strobe is ignored when bit 24 is 0 or bit 27 is 1. In that case busy stays 0, `fuse_rd` stays 0 and the data register keeps its value.
- R6: A latched address at or beyond 512 / WORD_BYTES completes with the normal latency and leaves all zeros in the data register, whatever the array returns.
- R7: With WORD_BYTES = 1, bits 31:8 of the data register always read 0.
- R8: Write-path fields in the control register are stored and read back unchanged and start no array access. They are bits 23:16 (byte data), bit 12 (enable), bit 13 (start) and bit 14 (busy).
- R9: Bit 10 of the configuration register is stored and read back. Its other bits read 0.
- R10: `fuse_pd` follows the stored control bit 27.
- R11: Busy bit 26 is read-only: writing 1 to it does not make it read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fuse_pd | output | 1 | Array power-down |
| fuse_rd | output | 1 | Array read request; high while a read runs |
| fuse_addr | output | 11 | Latched word address toward the array |
| fuse_rdata | input | 32 | Array word, byte 0 in bits 7:0 |

## Verification
The bench builds two copies side by side. One uses four-byte words with a latency of 8 cycles, and the other uses one-byte words with a latency of 3 cycles. Running both latencies shows that the busy window tracks the parameter rather than a fixed count. The four-byte copy puts the out-of-range boundary at word 128, and the one-byte copy puts it at 512, so both edges of the valid range are reached. In the one-byte copy the array model drives nonzero upper bits, so any leak into bits 31:8 of the data register becomes visible.

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int RD_LATENCY  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fuse_pd,
  output logic        fuse_rd,
  output logic [10:0] fuse_addr,
  input  logic [31:0] fuse_rdata
);
  localparam int WORDS  = ARRAY_BYTES / WORD_BYTES;
  localparam int DATA_W = 8 * WORD_BYTES;
  localparam int CNT_W  = $clog2(RD_LATENCY + 1);
  localparam logic [31:0] DATA_MASK = {32{1'b1}} >> (32 - DATA_W);
  localparam logic [4:0] OFS_CTRL = 5'h04;
  localparam logic [4:0] OFS_DATA = 5'h08;
  localparam logic [4:0] OFS_CFG  = 5'h10;

  logic [10:0]      addr_fld_q, lat_addr_q;
  logic [7:0]       wbyte_q;
  logic [2:0]       wctl_q;
  logic             set_q, start_q, rden_q, pd_q, enc_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      data_q;

  wire wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  wire wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
  wire set_rise = wr_ctrl && reg_wdata[11] && !set_q && !busy_q;
  wire go       = wr_ctrl && reg_wdata[25] && !start_q && reg_wdata[24]
                  && !reg_wdata[27] && !busy_q;
  wire in_range = 32'(lat_addr_q) < WORDS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_fld_q <= '0;
      set_q      <= 1'b0;
      wctl_q     <= '0;
      wbyte_q    <= '0;
      rden_q     <= 1'b0;
      start_q    <= 1'b0;
      pd_q       <= 1'b1;
      enc_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        addr_fld_q <= reg_wdata[10:0];
        set_q      <= reg_wdata[11];
        wctl_q     <= reg_wdata[14:12];
        wbyte_q    <= reg_wdata[23:16];
        rden_q     <= reg_wdata[24];
        start_q    <= reg_wdata[25];
        pd_q       <= reg_wdata[27];
      end
      if (wr_cfg) enc_q <= reg_wdata[10];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      data_q     <= '0;
    end else begin
      if (set_rise) lat_addr_q <= reg_wdata[10:0];
      if (go) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(RD_LATENCY - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          data_q <= in_range ? (fuse_rdata & DATA_MASK) : '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {4'b0, pd_q, busy_q, start_q, rden_q, wbyte_q,
                             1'b0, wctl_q, set_q, addr_fld_q};
      OFS_DATA: reg_rdata = data_q;
      OFS_CFG:  reg_rdata = {21'b0, enc_q, 10'b0};
      default:  reg_rdata = '0;
    endcase
  end

  assign fuse_pd   = pd_q;
  assign fuse_rd   = busy_q;
  assign fuse_addr = lat_addr_q;
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk #(
  parameter int WORD_BYTES = 4,
  parameter int RD_LATENCY = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        fuse_pd,
  input logic        fuse_rd,
  input logic [10:0] fuse_addr
);
  logic [15:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (fuse_rd) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_rd) |-> run_len == 16'(RD_LATENCY));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rd && $past(fuse_rd)) |-> $stable(fuse_addr));

  assert_no_read_powered_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_rd) |-> !fuse_pd);

  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rd && $past(fuse_rd) && reg_addr == 5'h08 && $past(reg_addr) == 5'h08)
      |-> $stable(reg_rdata));

  generate
    if (WORD_BYTES == 1) begin : g_byte
      assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'h08) |-> reg_rdata[31:8] == 24'h0);
    end
  endgenerate
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.WORD_BYTES(WORD_BYTES), .RD_LATENCY(RD_LATENCY)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fuse_pd(fuse_pd), .fuse_rd(fuse_rd), .fuse_addr(fuse_addr)
);

// File: tb/fuse_rd_ctrl_tb_top.sv
module fuse_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_A = 8;
  localparam int LAT_B = 3;
  localparam int NVEC = 6;
  localparam logic [10:0] VEC_ADDR [NVEC] = '{11'd0, 11'd1, 11'd5, 11'd127, 11'd128, 11'd2047};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_a = 1'b0, wr_b = 1'b0;
  logic [4:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b, frd_a, frd_b;
  logic        pd_a, pd_b, rd_a, rd_b;
  logic [10:0] fa_a, fa_b;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input int b);
    return 8'((b * 7) ^ (b >> 3) ^ 8'h5A);
  endfunction
  function automatic logic [31:0] word4(input int a);
    return {mbyte(4*a+3), mbyte(4*a+2), mbyte(4*a+1), mbyte(4*a)};
  endfunction

  always_comb frd_a = (32'(fa_a) < 128) ? word4(int'(fa_a)) : 32'hDEAD_BEEF;
  always_comb frd_b = (32'(fa_b) < 512) ? {24'hABCDEF, mbyte(int'(fa_b))} : 32'hFFFF_FFFF;

  fuse_rd_ctrl #(.WORD_BYTES(4), .RD_LATENCY(LAT_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(raddr), .reg_wdata(wdata),
    .reg_rdata(rdata_a), .fuse_pd(pd_a), .fuse_rd(rd_a), .fuse_addr(fa_a), .fuse_rdata(frd_a));
  fuse_rd_ctrl #(.WORD_BYTES(1), .RD_LATENCY(LAT_B)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(raddr), .reg_wdata(wdata),
    .reg_rdata(rdata_b), .fuse_pd(pd_b), .fuse_rd(rd_b), .fuse_addr(fa_b), .fuse_rdata(frd_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    raddr = a; wdata = d;
    if (sel) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [4:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = sel ? rdata_b : rdata_a;
  endtask

  task automatic fuse_read(input bit sel, input logic [10:0] w, input int lat,
                           input logic [31:0] exp, input string req);
    logic [31:0] v;
    logic [31:0] base;
    int hi;
    base = 32'h0100_0000 | 32'(w);
    wr(sel, 5'h04, base);
    wr(sel, 5'h04, base | 32'h800);
    wr(sel, 5'h04, base);
    check("R2 fuse_addr latched", 32'(sel ? fa_b : fa_a), 32'(w));
    wr(sel, 5'h04, base | 32'h0200_0000);
    rd(sel, 5'h04, v);
    check("R3 busy on first read", 32'(v[26]), 32'h1);
    hi = 0;
    for (int i = 0; i < 50; i++) begin
      if (i > 0) begin @(negedge clk); rd(sel, 5'h04, v); end
      if (!v[26]) break;
      hi++;
    end
    check("R4 busy length", 32'(hi), 32'(lat));
    rd(sel, 5'h08, v);
    check(req, v, exp);
    wr(sel, 5'h04, base);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 5'h04, v); check("R1 ctrl reset", v, 32'h0800_0000);
    rd(0, 5'h08, v); check("R1 data reset", v, 32'h0);
    rd(0, 5'h10, v); check("R1 cfg reset", v, 32'h0);
    check("R1 pd reset", 32'(pd_a), 32'h1);

    for (int k = 0; k < NVEC; k++)
      fuse_read(0, VEC_ADDR[k], LAT_A,
                (32'(VEC_ADDR[k]) < 128) ? word4(int'(VEC_ADDR[k])) : 32'h0,
                (32'(VEC_ADDR[k]) < 128) ? "R4 data word" : "R6 out of range zero");

    fuse_read(0, 11'd9, LAT_A, word4(9), "R4 data word");
    wr(0, 5'h04, 32'h0100_0000 | 32'd33);
    check("R2 no strobe keeps addr", 32'(fa_a), 32'd9);
    check("R10 pd follows bit", 32'(pd_a), 32'h0);

    rd(0, 5'h08, keep);
    wr(0, 5'h04, 32'h0200_0000 | 32'd9);
    rd(0, 5'h04, v); check("R5 no enable busy", 32'(v[26]), 32'h0);
    check("R5 no enable rd", 32'(rd_a), 32'h0);
    rd(0, 5'h08, v); check("R5 data kept", v, keep);
    wr(0, 5'h04, 32'h0100_0000);
    wr(0, 5'h04, 32'h0B00_0000);
    rd(0, 5'h04, v); check("R5 powered down busy", 32'(v[26]), 32'h0);
    check("R10 pd set", 32'(pd_a), 32'h1);
    wr(0, 5'h04, 32'h0800_0000);

    wr(0, 5'h04, 32'h08AB_7000);
    rd(0, 5'h04, v); check("R8 write fields", v, 32'h08AB_7000);
    check("R8 no access", 32'(rd_a), 32'h0);
    wr(0, 5'h04, 32'h0400_0000);
    rd(0, 5'h04, v); check("R11 busy read-only", v, 32'h0);

    wr(0, 5'h10, 32'hFFFF_FFFF);
    rd(0, 5'h10, v); check("R9 cfg bit", v, 32'h0000_0400);
    wr(0, 5'h10, 32'h0);
    rd(0, 5'h10, v); check("R9 cfg clear", v, 32'h0);

    fuse_read(1, 11'd3, LAT_B, {24'h0, mbyte(3)}, "R7 byte mode word");
    fuse_read(1, 11'd511, LAT_B, {24'h0, mbyte(511)}, "R7 byte mode top");
    fuse_read(1, 11'd512, LAT_B, 32'h0, "R6 byte mode out of range");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule